// File: doc/BRIEF.md
# Sliding-window metric initialisation controller

This block sequences the windowed schedule of a single soft-in/soft-out component decoder that works on one subblock of a parallel turbo decoder. A subblock of length M is cut into 16-step windows. When M is not a multiple of 16, the final window holds the remainder. Each window passes through four phases in a fixed order: dummy backward recursion, forward recursion, backward recursion, and LLR output. The phases of successive windows overlap, so that in time slot s the dummy unit works on window s, the forward unit on window s-1, the backward unit on window s-2, and the LLR stage on window s-3. Every slot lasts one full window time of 16 cycles.

For each window the block decides where every recursion gets its starting state-metric vector. The forward recursion of a subblock starts from the boundary α that the preceding decoder saved during the previous iteration. The dummy backward recursion of the last window starts from the β that the following decoder saved during the previous iteration. All other dummy recursions start from zero, which means equiprobable states. The backward recursion of the last window starts from the dummy βd that the following decoder computed over its first window in the current half-iteration. This decoder's own first-window βd is forwarded to the preceding decoder. Saved boundary vectors are kept in two banks, one for natural-order half-iterations and one for interleaved-order half-iterations. The add-compare-select datapath lies outside this block.

A vector carries 8 states of 9 bits each. State k sits at bits [9k+8:9k].

Top module: `swin_init_ctrl`

## Requirements
- R1: A start pulse with a nonzero length M begins a run. busy_o stays high for (ceil(M/16)+3)*16 cycles, and done_o is high only in the last of them. A start pulse with M=0 is ignored. A start pulse during a run restarts the schedule.
- R2: The subblock has ceil(M/16) windows. win_idx_o gives the slot number, which equals the window in the dummy phase. While a dummy window is active, win_len_o is 16 for every window except the last, which is M-16*(ceil(M/16)-1). Outside the dummy phase, win_len_o is 0.
- R3: Phase strobes are single-cycle pulses in the first cycle of a slot. In slot s, bd_go_o is set if s<n, al_go_o if 1<=s<=n, be_go_o if 2<=s<=n+1, and llr_go_o if 3<=s<=n+2, where n is the window count.
- R4: bd_src_o is 1 in the last window's dummy slot, and bd_init_o then equals the saved β of the active bank. In every other slot bd_src_o is 0 and bd_init_o is zero.
- R5: al_load_o is 1 only in slot 1, where window 0 starts its forward phase. al_init_o then equals the saved α of the active bank. In every other slot al_init_o is zero.
- R6: be_src_o is 1 in slot n+1, where the last window starts its backward phase. be_init_o then equals the neighbour βd captured in the current run. In every other slot be_src_o is 0 and be_init_o is zero. Each start clears the captured neighbour βd.
- R7: ileave_i at start selects the active bank (0 = natural order, 1 = interleaved order). A neighbour α or β capture outside a start cycle is written into the bank of the most recent start. The other bank keeps its contents.
- R8: first_iter_i at start clears both saved vectors of the selected bank to zero. The other bank is left untouched.
- R9: A capture of neighbour α, β or βd in the same cycle as a start is written into the newly selected bank. It overrides the first-iteration clear.
- R10: When own_bd_vld_i is asserted, own_bd_i appears on bd_to_prev_o one cycle later, together with a single-cycle bd_to_prev_vld_o.
- R11: After reset, busy_o, done_o, all strobes and bd_to_prev_vld_o are 0, and both banks hold zero vectors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hi_start_i | input | 1 | Half-iteration start pulse |
| first_iter_i | input | 1 | Clear the selected bank at start |
| ileave_i | input | 1 | Bank select at start (1 = interleaved order) |
| sub_len_i | input | 13 | Subblock length M |
| nbr_alpha_i | input | 72 | Boundary α from the preceding decoder |
| nbr_alpha_vld_i | input | 1 | Capture nbr_alpha_i |
| nbr_beta_i | input | 72 | Previous-iteration β from the following decoder |
| nbr_beta_vld_i | input | 1 | Capture nbr_beta_i |
| nbr_bd_i | input | 72 | First-window βd from the following decoder |
| nbr_bd_vld_i | input | 1 | Capture nbr_bd_i |
| own_bd_i | input | 72 | This decoder's first-window βd |
| own_bd_vld_i | input | 1 | own_bd_i valid |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Last cycle of the run |
| win_idx_o | output | 9 | Slot number (window in the dummy phase) |
| win_len_o | output | 5 | Length of the dummy-phase window |
| bd_go_o | output | 1 | Dummy backward phase start |
| al_go_o | output | 1 | Forward phase start |
| be_go_o | output | 1 | Backward phase start |
| llr_go_o | output | 1 | LLR phase start |
| bd_src_o | output | 1 | Dummy init source (1 = saved β) |
| bd_init_o | output | 72 | Dummy backward initial vector |
| al_load_o | output | 1 | Load forward initial vector |
| al_init_o | output | 72 | Forward initial vector |
| be_src_o | output | 1 | Backward init source (1 = neighbour βd) |
| be_init_o | output | 72 | Backward initial vector |
| bd_to_prev_o | output | 72 | βd sent to the preceding decoder |
| bd_to_prev_vld_o | output | 1 | bd_to_prev_o valid |

## Verification
A half-iteration start that clears a bank can fall in the same cycle as a neighbour boundary capture. The bench provokes this by raising the α, β and βd capture strobes in the very cycle of a first-iteration start. It then judges the outcome through the initial vectors that the same run issues: the α at slot 1, the βd source at the last dummy slot, and the β at slot n+1 must all carry the captured value and not zero. A separate run with the same start and no capture must present zeros at the same slots.

// File: rtl/swin_pkg.sv
package swin_pkg;
  typedef enum logic {BD_ZERO = 1'b0, BD_SAVED = 1'b1} bd_src_e;
  typedef enum logic {BE_DUMMY = 1'b0, BE_NBR = 1'b1} be_src_e;
endpackage

// File: rtl/swin_sched.sv
module swin_sched #(
  parameter int WIN_LEN = 16,
  parameter int LEN_W   = 13,
  parameter int SLOT_W  = 9,
  parameter int WL_W    = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [LEN_W-1:0]  sub_len_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              cyc0_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic [SLOT_W-1:0] nwin_o,
  output logic [WL_W-1:0]   last_len_o
);
  localparam int LOG_WL = $clog2(WIN_LEN);
  localparam int CYC_W  = LOG_WL;

  logic [LEN_W:0]    sum_w, nw_w;
  logic [LEN_W-1:0]  rem_w;
  logic [CYC_W-1:0]  cyc_q;
  logic [SLOT_W-1:0] slot_q, nwin_q, last_slot;
  logic [WL_W-1:0]   last_q;
  logic              busy_q, cyc_end;

  assign sum_w     = {1'b0, sub_len_i} + (LEN_W+1)'(WIN_LEN - 1);
  assign nw_w      = sum_w >> LOG_WL;
  assign rem_w     = sub_len_i - LEN_W'((nw_w - 1'b1) << LOG_WL);
  assign last_slot = nwin_q + SLOT_W'(2);
  assign cyc_end   = (cyc_q == CYC_W'(WIN_LEN - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      slot_q <= '0;
      cyc_q  <= '0;
      nwin_q <= '0;
      last_q <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      slot_q <= '0;
      cyc_q  <= '0;
      nwin_q <= SLOT_W'(nw_w);
      last_q <= WL_W'(rem_w);
    end else if (busy_q) begin
      cyc_q <= cyc_end ? '0 : cyc_q + 1'b1;
      if (cyc_end) begin
        if (slot_q == last_slot) busy_q <= 1'b0;
        else                     slot_q <= slot_q + 1'b1;
      end
    end
  end

  assign busy_o     = busy_q;
  assign done_o     = busy_q && cyc_end && (slot_q == last_slot);
  assign cyc0_o     = busy_q && (cyc_q == '0);
  assign slot_o     = slot_q;
  assign nwin_o     = nwin_q;
  assign last_len_o = last_q;
endmodule

// File: rtl/swin_bnd_store.sv
module swin_bnd_store #(
  parameter int VEC_W = 72
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             first_iter_i,
  input  logic             ileave_i,
  input  logic [VEC_W-1:0] nbr_alpha_i,
  input  logic             nbr_alpha_vld_i,
  input  logic [VEC_W-1:0] nbr_beta_i,
  input  logic             nbr_beta_vld_i,
  input  logic [VEC_W-1:0] nbr_bd_i,
  input  logic             nbr_bd_vld_i,
  input  logic [VEC_W-1:0] own_bd_i,
  input  logic             own_bd_vld_i,
  output logic [VEC_W-1:0] alpha_rd_o,
  output logic [VEC_W-1:0] beta_rd_o,
  output logic [VEC_W-1:0] nbd_o,
  output logic [VEC_W-1:0] fwd_o,
  output logic             fwd_vld_o
);
  logic             bank_q, wbank;
  logic [VEC_W-1:0] alpha_q [2];
  logic [VEC_W-1:0] beta_q  [2];
  logic [VEC_W-1:0] nbd_q, fwd_q;
  logic             fwd_vld_q;

  // captures on a start cycle belong to the run being started
  assign wbank = start_i ? ileave_i : bank_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bank_q     <= 1'b0;
      alpha_q[0] <= '0;
      alpha_q[1] <= '0;
      beta_q[0]  <= '0;
      beta_q[1]  <= '0;
      nbd_q      <= '0;
      fwd_q      <= '0;
      fwd_vld_q  <= 1'b0;
    end else begin
      if (start_i) begin
        bank_q <= ileave_i;
        nbd_q  <= '0;
        if (first_iter_i) begin
          alpha_q[ileave_i] <= '0;
          beta_q[ileave_i]  <= '0;
        end
      end
      if (nbr_alpha_vld_i) alpha_q[wbank] <= nbr_alpha_i;
      if (nbr_beta_vld_i)  beta_q[wbank]  <= nbr_beta_i;
      if (nbr_bd_vld_i)    nbd_q          <= nbr_bd_i;
      fwd_vld_q <= own_bd_vld_i;
      if (own_bd_vld_i) fwd_q <= own_bd_i;
    end
  end

  assign alpha_rd_o = alpha_q[bank_q];
  assign beta_rd_o  = beta_q[bank_q];
  assign nbd_o      = nbd_q;
  assign fwd_o      = fwd_q;
  assign fwd_vld_o  = fwd_vld_q;
endmodule

// File: rtl/swin_init_sel.sv
module swin_init_sel import swin_pkg::*; #(
  parameter int WIN_LEN = 16,
  parameter int VEC_W   = 72,
  parameter int SLOT_W  = 9,
  parameter int WL_W    = 5
) (
  input  logic              busy_i,
  input  logic              cyc0_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [SLOT_W-1:0] nwin_i,
  input  logic [WL_W-1:0]   last_len_i,
  input  logic [VEC_W-1:0]  alpha_rd_i,
  input  logic [VEC_W-1:0]  beta_rd_i,
  input  logic [VEC_W-1:0]  nbd_i,
  output logic [WL_W-1:0]   win_len_o,
  output logic              bd_go_o,
  output logic              al_go_o,
  output logic              be_go_o,
  output logic              llr_go_o,
  output logic              bd_src_o,
  output logic [VEC_W-1:0]  bd_init_o,
  output logic              al_load_o,
  output logic [VEC_W-1:0]  al_init_o,
  output logic              be_src_o,
  output logic [VEC_W-1:0]  be_init_o
);
  logic    bd_act, al_act, be_act, llr_act;
  bd_src_e bd_sel;
  be_src_e be_sel;

  always_comb begin
    bd_act  = slot_i < nwin_i;
    al_act  = (slot_i >= SLOT_W'(1)) && (slot_i <= nwin_i);
    be_act  = (slot_i >= SLOT_W'(2)) && (slot_i <= nwin_i + SLOT_W'(1));
    llr_act = (slot_i >= SLOT_W'(3)) && (slot_i <= nwin_i + SLOT_W'(2));
    bd_sel  = (busy_i && slot_i == nwin_i - SLOT_W'(1)) ? BD_SAVED : BD_ZERO;
    be_sel  = (busy_i && slot_i == nwin_i + SLOT_W'(1)) ? BE_NBR : BE_DUMMY;
  end

  assign bd_go_o   = cyc0_i && bd_act;
  assign al_go_o   = cyc0_i && al_act;
  assign be_go_o   = cyc0_i && be_act;
  assign llr_go_o  = cyc0_i && llr_act;

  assign win_len_o = !(busy_i && bd_act) ? '0 :
                     (bd_sel == BD_SAVED) ? last_len_i : WL_W'(WIN_LEN);

  assign bd_src_o  = (bd_sel == BD_SAVED);
  assign bd_init_o = (bd_sel == BD_SAVED) ? beta_rd_i : '0;
  assign al_load_o = busy_i && (slot_i == SLOT_W'(1));
  assign al_init_o = al_load_o ? alpha_rd_i : '0;
  assign be_src_o  = (be_sel == BE_NBR);
  assign be_init_o = (be_sel == BE_NBR) ? nbd_i : '0;
endmodule

// File: rtl/swin_init_ctrl.sv
module swin_init_ctrl #(
  parameter  int WIN_LEN  = 16,
  parameter  int N_STATES = 8,
  parameter  int METRIC_W = 9,
  parameter  int MAX_SUB  = 6144,
  localparam int VEC_W    = N_STATES * METRIC_W,
  localparam int LEN_W    = $clog2(MAX_SUB + 1),
  localparam int MAX_WIN  = (MAX_SUB + WIN_LEN - 1) / WIN_LEN,
  localparam int SLOT_W   = $clog2(MAX_WIN + 4),
  localparam int WL_W     = $clog2(WIN_LEN + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hi_start_i,
  input  logic              first_iter_i,
  input  logic              ileave_i,
  input  logic [LEN_W-1:0]  sub_len_i,
  input  logic [VEC_W-1:0]  nbr_alpha_i,
  input  logic              nbr_alpha_vld_i,
  input  logic [VEC_W-1:0]  nbr_beta_i,
  input  logic              nbr_beta_vld_i,
  input  logic [VEC_W-1:0]  nbr_bd_i,
  input  logic              nbr_bd_vld_i,
  input  logic [VEC_W-1:0]  own_bd_i,
  input  logic              own_bd_vld_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [SLOT_W-1:0] win_idx_o,
  output logic [WL_W-1:0]   win_len_o,
  output logic              bd_go_o,
  output logic              al_go_o,
  output logic              be_go_o,
  output logic              llr_go_o,
  output logic              bd_src_o,
  output logic [VEC_W-1:0]  bd_init_o,
  output logic              al_load_o,
  output logic [VEC_W-1:0]  al_init_o,
  output logic              be_src_o,
  output logic [VEC_W-1:0]  be_init_o,
  output logic [VEC_W-1:0]  bd_to_prev_o,
  output logic              bd_to_prev_vld_o
);
  logic              go, cyc0;
  logic [SLOT_W-1:0] nwin;
  logic [WL_W-1:0]   last_len;
  logic [VEC_W-1:0]  alpha_rd, beta_rd, nbd;

  assign go = hi_start_i && (sub_len_i != '0);

  swin_sched #(.WIN_LEN(WIN_LEN), .LEN_W(LEN_W), .SLOT_W(SLOT_W), .WL_W(WL_W)) u_sched (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(go), .sub_len_i(sub_len_i),
    .busy_o(busy_o), .done_o(done_o), .cyc0_o(cyc0), .slot_o(win_idx_o),
    .nwin_o(nwin), .last_len_o(last_len)
  );

  swin_bnd_store #(.VEC_W(VEC_W)) u_store (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(go), .first_iter_i(first_iter_i),
    .ileave_i(ileave_i),
    .nbr_alpha_i(nbr_alpha_i), .nbr_alpha_vld_i(nbr_alpha_vld_i),
    .nbr_beta_i(nbr_beta_i), .nbr_beta_vld_i(nbr_beta_vld_i),
    .nbr_bd_i(nbr_bd_i), .nbr_bd_vld_i(nbr_bd_vld_i),
    .own_bd_i(own_bd_i), .own_bd_vld_i(own_bd_vld_i),
    .alpha_rd_o(alpha_rd), .beta_rd_o(beta_rd), .nbd_o(nbd),
    .fwd_o(bd_to_prev_o), .fwd_vld_o(bd_to_prev_vld_o)
  );

  swin_init_sel #(.WIN_LEN(WIN_LEN), .VEC_W(VEC_W), .SLOT_W(SLOT_W), .WL_W(WL_W)) u_sel (
    .busy_i(busy_o), .cyc0_i(cyc0), .slot_i(win_idx_o), .nwin_i(nwin),
    .last_len_i(last_len), .alpha_rd_i(alpha_rd), .beta_rd_i(beta_rd), .nbd_i(nbd),
    .win_len_o(win_len_o), .bd_go_o(bd_go_o), .al_go_o(al_go_o), .be_go_o(be_go_o),
    .llr_go_o(llr_go_o), .bd_src_o(bd_src_o), .bd_init_o(bd_init_o),
    .al_load_o(al_load_o), .al_init_o(al_init_o), .be_src_o(be_src_o),
    .be_init_o(be_init_o)
  );
endmodule

// File: rtl/swin_init_ctrl_chk.sv
module swin_init_ctrl_chk #(
  parameter int WIN_LEN = 16,
  parameter int VEC_W   = 72,
  parameter int LEN_W   = 13,
  parameter int SLOT_W  = 9,
  parameter int WL_W    = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              hi_start_i,
  input logic [LEN_W-1:0]  sub_len_i,
  input logic [VEC_W-1:0]  own_bd_i,
  input logic              own_bd_vld_i,
  input logic              busy_o,
  input logic              done_o,
  input logic [SLOT_W-1:0] win_idx_o,
  input logic [WL_W-1:0]   win_len_o,
  input logic              bd_go_o,
  input logic              al_go_o,
  input logic              be_go_o,
  input logic              bd_src_o,
  input logic [VEC_W-1:0]  bd_init_o,
  input logic              al_load_o,
  input logic              be_src_o,
  input logic [VEC_W-1:0]  bd_to_prev_o,
  input logic              bd_to_prev_vld_o
);
  int m_q;
  int nwin_c;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) m_q <= 0;
    else if (hi_start_i && sub_len_i != '0) m_q <= int'(sub_len_i);
  end
  assign nwin_c = (m_q + WIN_LEN - 1) / WIN_LEN;

  a_r1_done_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !hi_start_i |=> !busy_o);
  a_r2_len_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bd_go_o |-> (win_len_o != '0) && (int'(win_len_o) <= WIN_LEN));
  a_r3_bd_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bd_go_o |=> !bd_go_o);
  a_r3_be_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    be_go_o |=> !be_go_o);
  a_r4_saved_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bd_go_o && bd_src_o |-> int'(win_idx_o) == nwin_c - 1);
  a_r4_zero_init: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bd_go_o && !bd_src_o |-> bd_init_o == '0);
  a_r5_alpha_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    al_load_o && al_go_o |-> int'(win_idx_o) == 1);
  a_r6_nbr_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    be_go_o && be_src_o |-> int'(win_idx_o) == nwin_c + 1);
  a_r10_fwd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    own_bd_vld_i |=> bd_to_prev_vld_o && bd_to_prev_o == $past(own_bd_i));
endmodule

bind swin_init_ctrl swin_init_ctrl_chk #(
  .WIN_LEN(WIN_LEN), .VEC_W(VEC_W), .LEN_W(LEN_W), .SLOT_W(SLOT_W), .WL_W(WL_W)
) u_chk (.*);

// File: tb/sim_swin_init_ctrl.sv
`timescale 1ns/1ps
module sim_swin_init_ctrl;
  localparam int V = 72;

  logic clk = 1'b0, rst_n = 1'b0;
  logic hi_start = 0, first_iter = 0, ileave = 0;
  logic [12:0] sub_len = '0;
  logic [V-1:0] nbr_alpha = '0, nbr_beta = '0, nbr_bd = '0, own_bd = '0;
  logic nbr_alpha_vld = 0, nbr_beta_vld = 0, nbr_bd_vld = 0, own_bd_vld = 0;
  logic busy, done, bd_go, al_go, be_go, llr_go, bd_src, al_load, be_src, fwd_vld;
  logic [8:0] win_idx;
  logic [4:0] win_len;
  logic [V-1:0] bd_init, al_init, be_init, fwd;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  swin_init_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .hi_start_i(hi_start), .first_iter_i(first_iter),
    .ileave_i(ileave), .sub_len_i(sub_len),
    .nbr_alpha_i(nbr_alpha), .nbr_alpha_vld_i(nbr_alpha_vld),
    .nbr_beta_i(nbr_beta), .nbr_beta_vld_i(nbr_beta_vld),
    .nbr_bd_i(nbr_bd), .nbr_bd_vld_i(nbr_bd_vld),
    .own_bd_i(own_bd), .own_bd_vld_i(own_bd_vld),
    .busy_o(busy), .done_o(done), .win_idx_o(win_idx), .win_len_o(win_len),
    .bd_go_o(bd_go), .al_go_o(al_go), .be_go_o(be_go), .llr_go_o(llr_go),
    .bd_src_o(bd_src), .bd_init_o(bd_init), .al_load_o(al_load), .al_init_o(al_init),
    .be_src_o(be_src), .be_init_o(be_init), .bd_to_prev_o(fwd), .bd_to_prev_vld_o(fwd_vld)
  );

  // subblock length, window count, last window length
  localparam int NV = 8;
  localparam int TM [NV] = '{1, 15, 16, 17, 40, 100, 768, 6144};
  localparam int TN [NV] = '{1, 1, 1, 2, 3, 7, 48, 384};
  localparam int TL [NV] = '{1, 15, 16, 1, 8, 4, 16, 16};

  task automatic eq(input string tag, input logic [V-1:0] act, input logic [V-1:0] exp_v);
    n_chk++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp_v);
    end
  endtask

  task automatic cap_ab(input logic [V-1:0] a, input logic [V-1:0] b);
    @(negedge clk);
    nbr_alpha = a; nbr_beta = b; nbr_alpha_vld = 1; nbr_beta_vld = 1;
    @(negedge clk);
    nbr_alpha_vld = 0; nbr_beta_vld = 0;
  endtask

  // one half-iteration with full per-slot checks
  task automatic run_half(input int m, input int n, input int last, input bit fi,
                          input bit il, input logic [V-1:0] ea, input logic [V-1:0] eb,
                          input logic [V-1:0] enb, input bit co_cap);
    @(negedge clk);
    hi_start = 1; first_iter = fi; ileave = il; sub_len = 13'(m);
    if (co_cap) begin
      nbr_alpha = ea; nbr_beta = eb; nbr_bd = enb;
      nbr_alpha_vld = 1; nbr_beta_vld = 1; nbr_bd_vld = 1;
    end
    @(negedge clk);
    hi_start = 0; first_iter = 0;
    nbr_alpha_vld = 0; nbr_beta_vld = 0; nbr_bd_vld = 0;
    for (int s = 0; s <= n + 2; s++) begin
      eq("R1 busy", V'(busy), V'(1));
      eq("R2 win_idx", V'(win_idx), V'(s));
      eq("R2 win_len", V'(win_len), V'(s < n ? (s == n - 1 ? last : 16) : 0));
      eq("R3 bd_go", V'(bd_go), V'(s < n));
      eq("R3 al_go", V'(al_go), V'(s >= 1 && s <= n));
      eq("R3 be_go", V'(be_go), V'(s >= 2 && s <= n + 1));
      eq("R3 llr_go", V'(llr_go), V'(s >= 3 && s <= n + 2));
      eq("R4 bd_src", V'(bd_src), V'(s == n - 1));
      eq("R4 bd_init", bd_init, (s == n - 1) ? eb : '0);
      eq("R5 al_load", V'(al_load), V'(s == 1));
      eq("R5 al_init", al_init, (s == 1) ? ea : '0);
      eq("R6 be_src", V'(be_src), V'(s == n + 1));
      eq("R6 be_init", be_init, (s == n + 1) ? enb : '0);
      if (s == 0 && !co_cap) begin
        nbr_bd = enb; nbr_bd_vld = 1;
      end
      @(negedge clk);
      nbr_bd_vld = 0;
      if (s == 0) eq("R3 strobe width", V'({bd_go, al_go, be_go, llr_go}), V'(0));
      repeat (14) @(negedge clk);
      eq("R1 done", V'(done), V'(s == n + 2));
      @(negedge clk);
    end
    eq("R1 idle after run", V'(busy), V'(0));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R1 watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [V-1:0] a0, b0, a1, b1, cv;
    a0 = {8{9'h0a5}}; b0 = {8{9'h13c}}; a1 = {8{9'h071}}; b1 = {8{9'h1e2}};
    cv = {9'd1, 9'd2, 9'd3, 9'd4, 9'd5, 9'd6, 9'd7, 9'd8};
    repeat (3) @(negedge clk);
    // R11 reset state
    eq("R11 busy", V'(busy), V'(0));
    eq("R11 done", V'(done), V'(0));
    eq("R11 strobes", V'({bd_go, al_go, be_go, llr_go}), V'(0));
    eq("R11 fwd_vld", V'(fwd_vld), V'(0));
    rst_n = 1;
    @(negedge clk);
    // R11 banks zero after reset, R2/R3 table of lengths
    for (int i = 0; i < NV; i++)
      run_half(TM[i], TN[i], TL[i], (i != 0), 1'b0, '0, '0, {8{9'(TM[i] + 3)}}, 1'b0);
    // R7 bank separation
    cap_ab(a0, b0);
    run_half(40, 3, 8, 1'b1, 1'b1, '0, '0, cv, 1'b0);
    cap_ab(a1, b1);
    run_half(40, 3, 8, 1'b0, 1'b0, a0, b0, cv, 1'b0);
    run_half(17, 2, 1, 1'b0, 1'b1, a1, b1, cv, 1'b0);
    // R8 clear of the selected bank only
    run_half(33, 3, 1, 1'b1, 1'b0, '0, '0, cv, 1'b0);
    run_half(33, 3, 1, 1'b0, 1'b1, a1, b1, cv, 1'b0);
    // R9 capture coinciding with a first-iteration start
    run_half(20, 2, 4, 1'b1, 1'b0, cv, ~cv, a0, 1'b1);
    run_half(8, 1, 8, 1'b0, 1'b0, cv, ~cv, b1, 1'b0);
    // R1 zero length ignored
    @(negedge clk);
    hi_start = 1; sub_len = '0;
    @(negedge clk);
    hi_start = 0;
    eq("R1 zero length busy", V'(busy), V'(0));
    repeat (3) @(negedge clk);
    eq("R1 zero length strobes", V'({bd_go, al_go, be_go, llr_go}), V'(0));
    // R1 restart during a run
    hi_start = 1; sub_len = 13'd100; ileave = 0;
    @(negedge clk);
    hi_start = 0;
    repeat (40) @(negedge clk);
    eq("R1 busy before restart", V'(busy), V'(1));
    run_half(17, 2, 1, 1'b0, 1'b0, cv, ~cv, a1, 1'b0);
    // R10 forward to preceding decoder
    @(negedge clk);
    own_bd = b0; own_bd_vld = 1;
    @(negedge clk);
    own_bd_vld = 0; own_bd = '0;
    eq("R10 fwd_vld", V'(fwd_vld), V'(1));
    eq("R10 fwd value", fwd, b0);
    @(negedge clk);
    eq("R10 fwd_vld pulse", V'(fwd_vld), V'(0));
    eq("R10 fwd held", fwd, b0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule